// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes from a host into asynchronous serial frames on one output line. The host writes a byte into a one-entry holding stage. As soon as the shifter is free, the byte moves into an internal frame register and is sent. The host can therefore queue the next byte while the current one is still on the line. The host reads two flags to pace its writes: one shows that the holding stage is empty, and the other shows that the whole transmitter has drained.

The frame format is set at run time through configuration inputs: 5 to 8 data bits, optional parity (odd, even or stuck at a fixed level) and one or two stop bits. A break input pulls the line low for as long as it is held. Bit timing comes from an oversampling enable, made by dividing the input clock by a 16-bit divisor. Each serial bit lasts 16 of those enables. The configuration is sampled when a byte enters the shifter, so it can be changed while a frame is being sent without disturbing that frame.

Top module: `serial_tx`

## Requirements
- R1: After reset, and whenever the transmitter is idle and break is low, `txd` is 1, `hold_empty` is 1 and `tx_idle` is 1.
- R2: A frame begins with a 0 start bit, followed by the data bits with bit 0 first, followed by the stop bits at 1. Every bit lasts exactly 16 × `divisor` clock cycles. The start bit begins on the clock edge at which the byte enters the shifter.
- R3: `word_len` selects the data-bit count: 2'b00 gives 5 bits, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Byte bits above the selected count are not sent.
- R4: With `par_en`=1 and `par_stick`=0, one parity bit follows the last data bit. With `par_even`=1 the data bits plus parity hold an even number of ones. With `par_even`=0 they hold an odd number.
- R5: With `par_en`=1 and `par_stick`=1, the parity bit is 1 when `par_even`=0 and 0 when `par_even`=1, whatever the data.
- R6: `two_stop`=0 gives one stop bit and `two_stop`=1 gives two. `tx_idle` rises on the edge that ends the last stop bit, if no byte is waiting.
- R7: A `divisor` of 0 gives the same timing as a `divisor` of 1 (16 cycles per bit).
- R8: While `brk` is 1, `txd` is 0. Break does not change frame timing or the flags.
- R9: A write while a frame is being sent is held. `hold_empty` is 0 in the cycle after the write. The held byte's start bit follows the previous frame's last stop bit with no gap.
- R10: A write is accepted when the holding stage is empty, or in the cycle when the held byte moves into the shifter. Any other write is ignored.
- R11: `tx_idle` is 1 only when both the holding stage and the shifter are empty.
- R12: The frame format is captured when a byte enters the shifter. Configuration changes during a frame apply only to later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 16 | Clock divisor for the 16x oversampling enable (0 acts as 1) |
| wr_en | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Byte to send |
| word_len | input | 2 | Data-bit count select (00=5 … 11=8) |
| two_stop | input | 1 | 1 selects two stop bits |
| par_en | input | 1 | Adds a parity bit |
| par_even | input | 1 | Even parity when 1, odd when 0 |
| par_stick | input | 1 | Parity bit forced to the inverse of `par_even` |
| brk | input | 1 | Forces the line low while 1 |
| txd | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding stage can take a byte |
| tx_idle | output | 1 | Holding stage and shifter both empty |

## Verification
Two events can fall in the same cycle: a host write, and the move of the held byte into the shifter at the end of a frame. The test raises `wr_en` exactly in the final cycle of a frame while another byte is already waiting. It first queues a third byte, which must be dropped, and it changes the format mid-frame. Success means three frames run back to back with no gap: the old format first, then the new format for both later bytes, with the dropped byte never appearing. `hold_empty` must stay low while the newly written byte waits.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    // Frame format, sampled when a byte enters the shifter
    typedef struct packed {
        logic [1:0] wlen;
        logic       two_stop;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } txcfg_t;

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             restart,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } baud_st_t;

    baud_st_t         st_d, st_q;
    logic [DIV_W-1:0] term;

    always_comb begin
        // zero divisor behaves as one
        term = (divisor == '0) ? '0 : divisor - DIV_W'(1);
        tick = (st_q.cnt >= term);
        st_d = st_q;
        if (restart || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              valid,
    output logic [DATA_W-1:0] data
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } hold_st_t;

    hold_st_t st_d, st_q;
    logic     accept;

    always_comb begin
        accept = wr_en && (!st_q.valid || take);
        st_d   = st_q;
        if (take) begin
            st_d.valid = 1'b0;
        end
        if (accept) begin
            st_d.valid = 1'b1;
            st_d.data  = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.valid;
    assign data  = st_q.data;

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import serial_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold_valid,
    input  logic [DATA_W-1:0] hold_data,
    input  txcfg_t            cfg,
    output logic              take,
    output logic              line,
    output logic              busy
);

    localparam int MIN_BITS = DATA_W - 3;
    localparam int FRAME_W  = DATA_W + 4;
    localparam int LEFT_W   = $clog2(FRAME_W + 1);
    localparam int SUB_W    = (OVS > 1) ? $clog2(OVS) : 1;

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] frame;
        logic [LEFT_W-1:0]  left;
        logic [SUB_W-1:0]   sub;
    } sh_st_t;

    sh_st_t             st_d, st_q;
    logic [FRAME_W-1:0] new_frame;
    logic [LEFT_W-1:0]  new_len;
    logic               par_bit;
    logic               odd_ones;
    logic               bit_end;
    logic               last_bit;
    int                 nd;

    // Frame assembly: start, data LSB first, parity, stop ones
    always_comb begin : build
        nd        = MIN_BITS + int'(cfg.wlen);
        odd_ones  = 1'b0;
        new_frame = '1;
        new_frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nd) begin
                new_frame[i+1] = hold_data[i];
                odd_ones       = odd_ones ^ hold_data[i];
            end
        end
        if (cfg.par_stick) begin
            par_bit = ~cfg.par_even;
        end else if (cfg.par_even) begin
            par_bit = odd_ones;
        end else begin
            par_bit = ~odd_ones;
        end
        for (int i = 1; i < FRAME_W; i++) begin
            if (cfg.par_en && (i == nd + 1)) begin
                new_frame[i] = par_bit;
            end
        end
        new_len = LEFT_W'(2 + nd + int'(cfg.par_en) + int'(cfg.two_stop));
    end

    // Bit sequencing
    always_comb begin : advance
        bit_end  = st_q.busy && tick && (st_q.sub == SUB_W'(OVS - 1));
        last_bit = bit_end && (st_q.left == LEFT_W'(1));
        take     = hold_valid && (!st_q.busy || last_bit);
        st_d     = st_q;
        if (st_q.busy && tick) begin
            st_d.sub = st_q.sub + SUB_W'(1);
        end
        if (bit_end) begin
            st_d.sub   = '0;
            st_d.frame = {1'b1, st_q.frame[FRAME_W-1:1]};
            st_d.left  = st_q.left - LEFT_W'(1);
            if (last_bit) begin
                st_d.busy = 1'b0;
            end
        end
        if (take) begin
            st_d.busy  = 1'b1;
            st_d.frame = new_frame;
            st_d.left  = new_len;
            st_d.sub   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line = st_q.busy ? st_q.frame[0] : 1'b1;
    assign busy = st_q.busy;

endmodule

// File: rtl/serial_tx.sv
module serial_tx
    import serial_tx_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        word_len,
    input  logic              two_stop,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              par_stick,
    input  logic              brk,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_idle
);

    txcfg_t            cfg;
    logic              tick;
    logic              take;
    logic              hold_valid;
    logic [DATA_W-1:0] hold_data;
    logic              line;
    logic              busy;

    always_comb begin
        cfg.wlen      = word_len;
        cfg.two_stop  = two_stop;
        cfg.par_en    = par_en;
        cfg.par_even  = par_even;
        cfg.par_stick = par_stick;
    end

    sertx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .restart (take),
        .tick    (tick)
    );

    sertx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .valid   (hold_valid),
        .data    (hold_data)
    );

    sertx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .hold_valid (hold_valid),
        .hold_data  (hold_data),
        .cfg        (cfg),
        .take       (take),
        .line       (line),
        .busy       (busy)
    );

    assign txd        = brk ? 1'b0 : line;
    assign hold_empty = ~hold_valid;
    assign tx_idle    = ~hold_valid & ~busy;

endmodule

// File: rtl/serial_tx_chk.sv
module serial_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic brk,
    input logic txd,
    input logic hold_empty,
    input logic tx_idle
);

    // R1
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idle && !brk) |-> txd);

    // R8
    break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !txd);

    // R11
    idle_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> hold_empty);

    // R9
    write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hold_empty) |=> !hold_empty);

    // R10
    fill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_empty) |-> $past(wr_en));

endmodule

bind serial_tx serial_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .brk        (brk),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_idle    (tx_idle)
);

// File: tb/tb_serial_tx.sv
module tb_serial_tx;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] divisor = 16'd1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [1:0]  word_len = 2'b11;
    logic        two_stop = 1'b0;
    logic        par_en = 1'b0;
    logic        par_even = 1'b0;
    logic        par_stick = 1'b0;
    logic        brk = 1'b0;
    logic        txd;
    logic        hold_empty;
    logic        tx_idle;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_tx dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .divisor    (divisor),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .word_len   (word_len),
        .two_stop   (two_stop),
        .par_en     (par_en),
        .par_even   (par_even),
        .par_stick  (par_stick),
        .brk        (brk),
        .txd        (txd),
        .hold_empty (hold_empty),
        .tx_idle    (tx_idle)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    function automatic int frame_len(input logic [1:0] wl, input logic pe, input logic ts);
        return 2 + 5 + int'(wl) + int'(pe) + int'(ts);
    endfunction

    function automatic logic exp_bit(input logic [7:0] d, input logic [1:0] wl, input logic pe,
                                     input logic ev, input logic st, input int k);
        int nd;
        int ones;
        logic odd;
        nd   = 5 + int'(wl);
        ones = 0;
        for (int i = 0; i < nd; i++) ones += int'(d[i]);
        odd = (ones % 2) == 1;
        if (k == 0) return 1'b0;
        if (k <= nd) return d[k-1];
        if (pe && k == nd + 1) begin
            if (st) return ~ev;
            return ev ? odd : ~odd;
        end
        return 1'b1;
    endfunction

    // returns half a cycle after the write edge
    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // called half a cycle before the frame's first edge; returns half a cycle before its last edge
    task automatic check_frame(input string tag, input logic [7:0] b, input logic [1:0] wl,
                               input logic pe, input logic ev, input logic st,
                               input logic ts, input int d);
        int n;
        n = frame_len(wl, pe, ts);
        repeat (8 * d) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            check(tag, $sformatf("byte %h bit %0d", b, k), txd, exp_bit(b, wl, pe, ev, st, k));
            if (k < n - 1) repeat (16 * d) @(negedge clk);
        end
        repeat (8 * d) @(negedge clk);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] b;
        logic       pe, ev, st;
        string      tag;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "txd in reset", txd, 1'b1);
        check("R1", "hold_empty in reset", hold_empty, 1'b1);
        check("R1", "tx_idle in reset", tx_idle, 1'b1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "txd after reset", txd, 1'b1);
        check("R1", "tx_idle after reset", tx_idle, 1'b1);

        // R3 R4 R5 R6: sweep word length, parity mode, stop count
        divisor = 16'd1;
        for (int wl = 0; wl < 4; wl++) begin
            for (int pm = 0; pm < 5; pm++) begin
                for (int ts = 0; ts < 2; ts++) begin
                    pe = (pm != 0);
                    ev = (pm == 2) || (pm == 4);
                    st = (pm >= 3);
                    word_len  = 2'(wl);
                    par_en    = pe;
                    par_even  = ev;
                    par_stick = st;
                    two_stop  = ts[0];
                    b = 8'(wl * 61 + pm * 23 + ts * 97 + 53);
                    if (pm == 0) tag = "R3";
                    else if (pm < 3) tag = "R4";
                    else tag = "R5";
                    write_byte(b);
                    check("R9", "hold_empty after write to idle", hold_empty, 1'b0);
                    check_frame(tag, b, 2'(wl), pe, ev, st, ts[0], 1);
                    check("R6", "tx_idle in last stop bit", tx_idle, 1'b0);
                    @(negedge clk);
                    check("R6", "tx_idle after last stop bit", tx_idle, 1'b1);
                    check("R6", "txd after frame", txd, 1'b1);
                end
            end
        end

        // R2 timing with divisor 3, 7 bits even parity two stops
        divisor = 16'd3; word_len = 2'b10; par_en = 1'b1; par_even = 1'b1;
        par_stick = 1'b0; two_stop = 1'b1;
        write_byte(8'h4B);
        check_frame("R2", 8'h4B, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 3);
        check("R2", "tx_idle before frame end", tx_idle, 1'b0);
        @(negedge clk);
        check("R2", "tx_idle at frame end", tx_idle, 1'b1);

        // R7 divisor zero acts as one
        divisor = 16'd0; word_len = 2'b11; par_en = 1'b0; two_stop = 1'b0;
        write_byte(8'hA5);
        check_frame("R7", 8'hA5, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        @(negedge clk);
        check("R7", "tx_idle at frame end", tx_idle, 1'b1);

        // R8 break while idle and mid-frame
        divisor = 16'd1;
        brk = 1'b1;
        @(negedge clk);
        check("R8", "txd under break idle", txd, 1'b0);
        check("R8", "tx_idle under break", tx_idle, 1'b1);
        brk = 1'b0;
        @(negedge clk);
        check("R8", "txd after break", txd, 1'b1);
        write_byte(8'hFF);
        repeat (8 + 48) @(negedge clk);
        brk = 1'b1;
        #1;
        check("R8", "txd under break mid-frame", txd, 1'b0);
        brk = 1'b0;
        #1;
        check("R8", "txd after break mid-frame", txd, 1'b1);
        for (int k = 4; k < 10; k++) begin
            repeat (16) @(negedge clk);
            check("R8", $sformatf("bit %0d after break", k), txd, exp_bit(8'hFF, 2'b11, 1'b0, 1'b0, 1'b0, k));
        end
        repeat (8) @(negedge clk);
        @(negedge clk);
        check("R8", "tx_idle after frame with break", tx_idle, 1'b1);

        // R9 R10 R12 double buffering, dropped write, write in transfer cycle
        divisor = 16'd2; word_len = 2'b11; par_en = 1'b0; par_even = 1'b0;
        par_stick = 1'b0; two_stop = 1'b0;
        write_byte(8'h3C);
        fork
            check_frame("R9", 8'h3C, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 2);
            begin
                repeat (40) @(negedge clk);
                write_byte(8'hC3);
                check("R9", "hold_empty with byte queued", hold_empty, 1'b0);
                check("R11", "tx_idle with byte queued", tx_idle, 1'b0);
                write_byte(8'h77);
                check("R10", "hold_empty after dropped write", hold_empty, 1'b0);
                word_len = 2'b01; par_en = 1'b1; par_even = 1'b1; two_stop = 1'b1;
            end
        join
        wr_en   = 1'b1;
        wr_data = 8'h5A;
        fork
            check_frame("R12", 8'hC3, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 2);
            begin
                @(negedge clk);
                wr_en = 1'b0;
                check("R10", "byte written in transfer cycle held", hold_empty, 1'b0);
            end
        join
        check_frame("R10", 8'h5A, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 2);
        @(negedge clk);
        check("R10", "idle after held bytes, dropped byte absent", tx_idle, 1'b1);
        check("R11", "hold_empty when idle", hold_empty, 1'b1);
        repeat (40) @(negedge clk);
        check("R10", "line stays high", txd, 1'b1);

        summary();
    end

endmodule